// File: doc/BRIEF.md
# Dual-Strobe Serial Word Receiver

This block receives serial avionics-style data words on several independent channels. An external conditioning stage has already turned the line into two strobes per channel. One pulses once for every logic-one bit, and the other pulses once for every logic-zero bit. Inside each channel, both strobes are brought into the system clock domain. Every rising edge shifts one bit into a 32-bit word, least significant bit first.

A word is accepted only when two checks pass. Its label field (word bits 8..1) must equal the label programmed for that channel. When the static parity enable is high, the word must also have odd parity over all 32 bits. An accepted word is placed on the channel's word output together with a one-cycle valid pulse, which goes to the host-side status and register logic. A partly received word is dropped in two cases: the line stays quiet for longer than a programmable idle count, or the two strobes are seen high together.

Top module: `strobe_word_rx`

## Requirements
- R1: A rising edge on the one-strobe shifts in a 1 and a rising edge on the zero-strobe shifts in a 0. The first bit of a word lands in word bit 0 and the 32nd bit lands in bit 31.
- R2: Suppose the 32nd strobe edge of an accepted word is driven just after clock edge n. Then `valid_o` of that channel is high for exactly the one cycle that follows edge n+4, with the word on `word_o`. This timing covers two synchronizer stages, the shift and the check register.
- R3: A completed word whose bits 8..1 differ from that channel's label byte in `label_i` produces no valid pulse.
- R4: With `parity_en_i` high, a completed word with an even number of ones produces no valid pulse.
- R5: With `parity_en_i` low, parity has no effect, and a word with a matching label is accepted whatever its number of ones.
- R6: While a word is partly received, consecutive bit edges must be no more than `idle_limit_i` clock cycles apart. If the spacing is larger, the partial word is discarded and the next bit starts a new word. A spacing exactly equal to the limit keeps the word.
- R7: If both strobes of a channel are high in the same synchronized cycle, no bit is taken and the partial word is discarded.
- R8: After reset, `word_o` and `valid_o` are zero. `word_o` changes only together with a valid pulse and otherwise holds the last accepted word.
- R9: Channels are independent. Traffic on one channel does not change the bit position, result or outputs of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| parity_en_i | input | 1 | Static enable for the odd-parity check |
| idle_limit_i | input | IDLE_W | Maximum clock cycles allowed between bits inside a word |
| label_i | input | NUM_CH*8 | Programmed label per channel; channel c uses bits 8c+7..8c |
| one_strobe_i | input | NUM_CH | Per-channel strobe pulsing for each received 1 |
| zero_strobe_i | input | NUM_CH | Per-channel strobe pulsing for each received 0 |
| word_o | output | NUM_CH*32 | Last accepted word per channel; channel c at bits 32c+31..32c |
| valid_o | output | NUM_CH | One-cycle pulse per channel on each accepted word |

## Verification
The hardest cases to reach from the ports are the idle-window boundary and a strobe conflict in the middle of a word. Both depend on the exact spacing between strobe edges, not on the word contents. The bench drives each bit with its own rise-to-rise period. This lets it stretch one gap inside a word to exactly the idle limit and then to one cycle more, and it lets it raise both strobes together after a dozen bits. A behavioural model tracks bit counts and gap times in plain integers and predicts the exact cycle of every valid pulse, so a word that should have been discarded shows up as a stray or misplaced pulse.

// File: rtl/swrx_pkg.sv
package swrx_pkg;
  localparam int unsigned WORD_W_DEF    = 32;
  localparam int unsigned LABEL_W_DEF   = 8;
  localparam int unsigned LABEL_LSB_DEF = 1;
  localparam int unsigned IDLE_W_DEF    = 16;
  localparam int unsigned SYNC_DEF      = 2;
endpackage

// File: rtl/swrx_sync.sv
module swrx_sync #(
  parameter int unsigned STAGES = swrx_pkg::SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      prev_q <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], strobe_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~prev_q;

  // R1
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/swrx_assembler.sv
module swrx_assembler #(
  parameter int unsigned WORD_W = swrx_pkg::WORD_W_DEF,
  parameter int unsigned IDLE_W = swrx_pkg::IDLE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              one_rise_i,
  input  logic              zero_rise_i,
  input  logic              one_lvl_i,
  input  logic              zero_lvl_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [IDLE_W:0]  ONE_I    = (IDLE_W+1)'(1);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDLE_W-1:0] idle_q;
  logic [IDLE_W:0]   idle_nxt;
  logic              bit_rise, conflict, idle_hit;

  assign bit_rise = one_rise_i | zero_rise_i;
  assign conflict = one_lvl_i & zero_lvl_i;
  assign idle_nxt = {1'b0, idle_q} + ONE_I;
  assign idle_hit = idle_nxt >= {1'b0, idle_limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      idle_q <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (conflict) begin
        cnt_q  <= '0;
        idle_q <= '0;
      end else if (bit_rise) begin
        sr_q   <= {one_rise_i, sr_q[WORD_W-1:1]};
        idle_q <= '0;
        if (cnt_q == LAST_BIT) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
          word_o <= {one_rise_i, sr_q[WORD_W-1:1]};
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end else if (cnt_q != '0) begin
        if (idle_hit) begin
          cnt_q  <= '0;
          idle_q <= '0;
        end else begin
          idle_q <= idle_nxt[IDLE_W-1:0];
        end
      end
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(WORD_W));
  // R7
  conflict_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict |=> (cnt_q == '0) && !done_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_rise && !conflict && cnt_q != '0 && idle_hit) |=> cnt_q == '0);
endmodule

// File: rtl/swrx_checker.sv
module swrx_checker #(
  parameter int unsigned WORD_W    = swrx_pkg::WORD_W_DEF,
  parameter int unsigned LABEL_W   = swrx_pkg::LABEL_W_DEF,
  parameter int unsigned LABEL_LSB = swrx_pkg::LABEL_LSB_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               parity_en_i,
  input  logic [LABEL_W-1:0] label_i,
  input  logic               done_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               valid_o,
  output logic [WORD_W-1:0]  word_o
);
  logic label_ok, parity_ok, accept;

  assign label_ok  = word_i[LABEL_LSB +: LABEL_W] == label_i;
  assign parity_ok = ~parity_en_i | (^word_i);
  assign accept    = done_i & label_ok & parity_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= accept;
      if (accept) word_o <= word_i;
    end
  end

  // R3
  label_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> word_o[LABEL_LSB +: LABEL_W] == label_i);
  // R4
  odd_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && parity_en_i) |-> ^word_o);
  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R8
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));
endmodule

// File: rtl/swrx_channel.sv
module swrx_channel #(
  parameter int unsigned WORD_W    = swrx_pkg::WORD_W_DEF,
  parameter int unsigned LABEL_W   = swrx_pkg::LABEL_W_DEF,
  parameter int unsigned LABEL_LSB = swrx_pkg::LABEL_LSB_DEF,
  parameter int unsigned IDLE_W    = swrx_pkg::IDLE_W_DEF,
  parameter int unsigned SYNC_N    = swrx_pkg::SYNC_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               parity_en_i,
  input  logic [IDLE_W-1:0]  idle_limit_i,
  input  logic [LABEL_W-1:0] label_i,
  input  logic               one_strobe_i,
  input  logic               zero_strobe_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               valid_o
);
  logic one_lvl, one_rise, zero_lvl, zero_rise, done;
  logic [WORD_W-1:0] raw_word;

  swrx_sync #(.STAGES(SYNC_N)) u_sync_one (
    .clk_i, .rst_ni, .strobe_i(one_strobe_i), .lvl_o(one_lvl), .rise_o(one_rise)
  );
  swrx_sync #(.STAGES(SYNC_N)) u_sync_zero (
    .clk_i, .rst_ni, .strobe_i(zero_strobe_i), .lvl_o(zero_lvl), .rise_o(zero_rise)
  );

  swrx_assembler #(.WORD_W(WORD_W), .IDLE_W(IDLE_W)) u_asm (
    .clk_i, .rst_ni,
    .one_rise_i(one_rise), .zero_rise_i(zero_rise),
    .one_lvl_i(one_lvl), .zero_lvl_i(zero_lvl),
    .idle_limit_i, .done_o(done), .word_o(raw_word)
  );

  swrx_checker #(.WORD_W(WORD_W), .LABEL_W(LABEL_W), .LABEL_LSB(LABEL_LSB)) u_chk (
    .clk_i, .rst_ni, .parity_en_i, .label_i,
    .done_i(done), .word_i(raw_word), .valid_o, .word_o
  );
endmodule

// File: rtl/strobe_word_rx.sv
module strobe_word_rx #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned WORD_W    = swrx_pkg::WORD_W_DEF,
  parameter int unsigned LABEL_W   = swrx_pkg::LABEL_W_DEF,
  parameter int unsigned LABEL_LSB = swrx_pkg::LABEL_LSB_DEF,
  parameter int unsigned IDLE_W    = swrx_pkg::IDLE_W_DEF,
  parameter int unsigned SYNC_N    = swrx_pkg::SYNC_DEF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      parity_en_i,
  input  logic [IDLE_W-1:0]         idle_limit_i,
  input  logic [NUM_CH*LABEL_W-1:0] label_i,
  input  logic [NUM_CH-1:0]         one_strobe_i,
  input  logic [NUM_CH-1:0]         zero_strobe_i,
  output logic [NUM_CH*WORD_W-1:0]  word_o,
  output logic [NUM_CH-1:0]         valid_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    swrx_channel #(
      .WORD_W(WORD_W), .LABEL_W(LABEL_W), .LABEL_LSB(LABEL_LSB),
      .IDLE_W(IDLE_W), .SYNC_N(SYNC_N)
    ) u_ch (
      .clk_i, .rst_ni, .parity_en_i, .idle_limit_i,
      .label_i      (label_i[c*LABEL_W +: LABEL_W]),
      .one_strobe_i (one_strobe_i[c]),
      .zero_strobe_i(zero_strobe_i[c]),
      .word_o       (word_o[c*WORD_W +: WORD_W]),
      .valid_o      (valid_o[c])
    );
  end
endmodule

// File: tb/sim_strobe_word_rx.sv
`timescale 1ns/1ps
module sim_strobe_word_rx;
  localparam int NCH = 4, WW = 32, IW = 16;

  logic clk = 1'b0, rst_n = 1'b0, par_en = 1'b1;
  logic [IW-1:0]    idle_lim = 16'd40;
  logic [NCH*8-1:0] labels = {8'hC3, 8'h5A, 8'h81, 8'h3F};
  logic [NCH-1:0]   one_s = '0, zero_s = '0;
  logic [NCH*WW-1:0] word;
  logic [NCH-1:0]   valid;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit finished = 0, started = 0;

  typedef struct { int ch; int at; logic [31:0] w; } ev_t;
  ev_t evq[$];
  int          m_cnt [NCH];
  int          m_last[NCH];
  logic [31:0] m_acc [NCH];
  logic [31:0] m_hold[NCH];

  strobe_word_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .parity_en_i(par_en), .idle_limit_i(idle_lim),
    .label_i(labels), .one_strobe_i(one_s), .zero_strobe_i(zero_s),
    .word_o(word), .valid_o(valid)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model: bit counts and gaps per channel
  task automatic model_bit(input int c, input bit v);
    if (m_cnt[c] > 0 && (cyc - m_last[c]) > int'(idle_lim)) m_cnt[c] = 0;
    m_acc[c][m_cnt[c]] = v;
    m_cnt[c]++;
    m_last[c] = cyc;
    if (m_cnt[c] == WW) begin
      ev_t e;
      m_cnt[c] = 0;
      if (m_acc[c][8:1] == labels[c*8 +: 8] && (!par_en || (^m_acc[c]))) begin
        e.ch = c; e.at = cyc + 4; e.w = m_acc[c];
        evq.push_back(e);
      end
    end
  endtask

  task automatic send_bit(input int c, input bit v, input int period);
    @(negedge clk);
    model_bit(c, v);
    if (v) one_s[c] = 1'b1; else zero_s[c] = 1'b1;
    @(negedge clk); @(negedge clk);
    one_s[c] = 1'b0; zero_s[c] = 1'b0;
    repeat (period - 3) @(negedge clk);
  endtask

  task automatic send_word(input int c, input logic [31:0] w, input int slow_idx, input int slow_per);
    for (int i = 0; i < WW; i++) send_bit(c, w[i], (i == slow_idx) ? slow_per : 4);
    repeat (20) @(negedge clk);
  endtask

  task automatic send_partial(input int c, input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(c, w[i], 4);
  endtask

  task automatic send_conflict(input int c);
    @(negedge clk);
    m_cnt[c] = 0;
    one_s[c] = 1'b1; zero_s[c] = 1'b1;
    @(negedge clk); @(negedge clk);
    one_s[c] = 1'b0; zero_s[c] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic [7:0] lab, input logic [22:0] pay, input bit odd);
    logic [31:0] w;
    w = {1'b0, pay[21:0], lab, pay[22]};
    if ((^w) != odd) w[31] = ~w[31];
    return w;
  endfunction

  task automatic hold_chk(input int c, input string req);
    chk(word[c*WW +: WW] == m_hold[c], req, word[c*WW +: WW], m_hold[c]);
  endtask

  // cycle-by-cycle comparison against model
  always @(negedge clk) begin : mon
    int idx;
    if (rst_n && started) begin
      for (int c = 0; c < NCH; c++) begin
        idx = -1;
        for (int i = 0; i < evq.size(); i++)
          if (evq[i].ch == c && evq[i].at == cyc) idx = i;
        if (idx >= 0) begin
          chk(valid[c] == 1'b1, "R2 valid pulse timing", 32'(valid[c]), 32'd1);
          chk(word[c*WW +: WW] == evq[idx].w, "R1 assembled word", word[c*WW +: WW], evq[idx].w);
          m_hold[c] = evq[idx].w;
          evq.delete(idx);
        end else if (valid[c]) begin
          chk(1'b0, "R3/R4/R6/R7/R9 unexpected valid", 32'(c), 32'hFFFF_FFFF);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_cnt[c] = 0; m_last[c] = 0; m_acc[c] = '0; m_hold[c] = '0;
    end
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(valid == '0, "R8 reset valid", 32'(valid), 32'd0);
    chk(word == '0, "R8 reset word", word[31:0], 32'd0);
    rst_n = 1'b1;
    started = 1;
    repeat (3) @(negedge clk);

    // R1 R2: good words, several patterns
    send_word(0, mk(8'h3F, 23'h5A5A5A, 1), -1, 4);
    send_word(0, mk(8'h3F, 23'h000000, 1), -1, 4);
    send_word(0, mk(8'h3F, 23'h7FFFFF, 1), -1, 4);
    hold_chk(0, "R8 hold after valid");

    // R3 label mismatch
    send_word(0, mk(8'h3E, 23'h123456, 1), -1, 4);
    hold_chk(0, "R3 R8 mismatch leaves word");

    // R4 even parity rejected
    send_word(1, mk(8'h81, 23'h0F0F0F, 0), -1, 4);
    hold_chk(1, "R4 even parity rejected");

    // R5 parity disabled
    par_en = 1'b0;
    send_word(1, mk(8'h81, 23'h0F0F0F, 0), -1, 4);
    hold_chk(1, "R5 parity ignored");
    send_word(1, mk(8'h80, 23'h0F0F0F, 0), -1, 4);
    hold_chk(1, "R3 mismatch with parity off");
    par_en = 1'b1;
    repeat (5) @(negedge clk);

    // R6 idle discard of partial word
    send_partial(2, 32'hFFFF_FFFF, 10);
    repeat (100) @(negedge clk);
    send_word(2, mk(8'h5A, 23'h2468AC, 1), -1, 4);
    hold_chk(2, "R6 word after idle discard");
    // R6 gap exactly at limit keeps word
    send_word(2, mk(8'h5A, 23'h13579B, 1), 14, 40);
    hold_chk(2, "R6 gap equal to limit");
    // R6 gap one over limit discards
    send_word(2, mk(8'h5A, 23'h0ACE00, 1), 14, 41);
    repeat (60) @(negedge clk);
    hold_chk(2, "R6 gap over limit discards");
    send_word(2, mk(8'h5A, 23'h3C3C3C, 1), -1, 4);

    // R7 conflict discards
    send_partial(3, 32'h0000_0FFF, 12);
    send_conflict(3);
    send_word(3, mk(8'hC3, 23'h6DB6DB, 1), -1, 4);
    hold_chk(3, "R7 word after conflict");
    send_partial(3, 32'hAAAA_AAAA, 31);
    send_conflict(3);
    send_bit(3, 1'b1, 4);
    repeat (60) @(negedge clk);
    hold_chk(3, "R7 conflict before last bit");

    // R9 channels concurrently
    fork
      send_word(0, mk(8'h3F, 23'h111111, 1), -1, 4);
      send_word(1, mk(8'h99, 23'h222222, 1), -1, 5);
      send_word(3, mk(8'hC3, 23'h333333, 1), -1, 6);
      begin send_partial(2, 32'h1, 5); send_conflict(2); end
    join
    repeat (60) @(negedge clk);
    for (int c = 0; c < NCH; c++) hold_chk(c, "R9 per-channel hold");

    chk(evq.size() == 0, "R2 missed pulses", 32'(evq.size()), 32'd0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule